// File: doc/BRIEF.md
# Interrupt flag and enable register

This block collects interrupt events from a peripheral's control lines and its two timers and reports them on one active-low request line. Each source owns one bit in a seven-bit flag register. A source sets its bit with a one-cycle set pulse. The bit clears in one of two ways: a clear pulse from the block that owns the source, or a flag-register write in which software marks the bits to drop with ones.

A seven-bit enable mask selects which flags can raise the request. Software changes the mask with a single write. The top data bit chooses the action: when it is one, the ones in the low seven bits set the matching enables; when it is zero, those ones clear them. Both registers can be read at any time. The flag read value carries a summary bit on top that shows whether any enabled flag is active. The request output is the inverse of that summary, driven as an ordinary push-pull signal. The shift-register slot in bit 2 exists only when the `HAS_SHIFT` parameter is set; otherwise it reads as zero.

Top module: `intr_flag_unit`

## Requirements
- R1: While reset is asserted and after its release, all flags and all enables are zero: the flag read is 0x00, the mask read is 0x80 and `irq_no` is 1.
- R2: A set pulse on `set_i[k]` makes flag bit k read as 1 from the cycle after the pulse. The bit positions are: 0 = port A second control line, 1 = port A first control line, 3 = port B second control line, 4 = port B first control line, 5 = timer 2, 6 = timer 1.
- R3: A write with `flag_wr_i` high clears every flag whose bit in `wdata_i[6:0]` is 1 and leaves every other flag unchanged.
- R4: A clear pulse on `clr_i[k]` clears flag bit k in the next cycle and leaves the other flags unchanged.
- R5: When a set pulse and a clear request (pulse or write) reach the same flag in the same cycle, the flag ends up set.
- R6: A write with `mask_wr_i` high and `wdata_i[7]` = 1 sets each enable bit whose bit in `wdata_i[6:0]` is 1 and leaves the rest unchanged.
- R7: A write with `mask_wr_i` high and `wdata_i[7]` = 0 clears each enable bit whose bit in `wdata_i[6:0]` is 1 and leaves the rest unchanged.
- R8: Bit 7 of the mask read value is always 1. Bits 6:0 hold the enables.
- R9: Bit 7 of the flag read value is 1 exactly when some flag and its enable bit are both 1. Bits 6:0 hold the flags.
- R10: `irq_no` is 0 exactly when flag read bit 7 is 1.
- R11: With `HAS_SHIFT` = 0, flag bit 2 stays 0 even when `set_i[2]` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 7 | Per-source set pulses |
| clr_i | input | 7 | Per-source clear pulses from the owning blocks |
| flag_wr_i | input | 1 | Flag register write strobe (write one to clear) |
| mask_wr_i | input | 1 | Enable register write strobe |
| wdata_i | input | 8 | Write data bus |
| flag_rdata_o | output | 8 | Flag read value: summary in bit 7, flags in bits 6:0 |
| mask_rdata_o | output | 8 | Enable read value: constant 1 in bit 7, enables in bits 6:0 |
| irq_no | output | 1 | Interrupt request, active low, push-pull |

## Verification
A wrong flag or enable bit appears on the read ports in the first cycle after the stimulus that caused it. Every register drives its read value without an extra pipeline stage, so a bad update cannot stay hidden for even one cycle. An error in the summary logic shows up at the same moment as a mismatch between flag read bit 7 and `irq_no`, or as a summary that disagrees with the AND of the flag and mask values on the two read ports. The bench sweeps every flag pattern against a spread of mask patterns and then runs a long pseudo-random sequence of overlapping set pulses, clear pulses and writes, checking all three outputs after every cycle.

// File: rtl/iflag_pkg.sv
package iflag_pkg;
  localparam int unsigned SRC_W = 7;

  // Bit positions are decoded by the source blocks; keep them fixed.
  typedef enum int unsigned {
    SRC_A_C2  = 0,
    SRC_A_C1  = 1,
    SRC_SHIFT = 2,
    SRC_B_C2  = 3,
    SRC_B_C1  = 4,
    SRC_TMR2  = 5,
    SRC_TMR1  = 6
  } irq_src_e;
endpackage

// File: rtl/iflag_bank.sv
module iflag_bank #(
  parameter int unsigned NSRC      = iflag_pkg::SRC_W,
  parameter bit          HAS_SHIFT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] flag_o
);
  localparam int unsigned SH = iflag_pkg::SRC_SHIFT;
  localparam logic [NSRC-1:0] KEEP =
    HAS_SHIFT ? {NSRC{1'b1}} : ~(NSRC'(1) << SH);

  logic [NSRC-1:0] flag_q, flag_d, clr_req;

  always_comb begin
    clr_req = clr_i | (wr_i ? wdata_i : '0);
    // Set wins over a clear request arriving in the same cycle.
    flag_d  = (set_i | (flag_q & ~clr_req)) & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    if (KEEP[k]) begin : g_live
      a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> flag_q[k]);
      a_r4_clear_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[k] && !set_i[k]) |=> !flag_q[k]);
      a_r3_write_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[k] && !set_i[k]) |=> !flag_q[k]);
      a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i[k] && !clr_i[k] && !(wr_i && wdata_i[k])) |=> $stable(flag_q[k]));
    end else begin : g_dead
      a_r11_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> !flag_o[k]);
    end
  end
endmodule

// File: rtl/ien_mask.sv
module ien_mask #(
  parameter int unsigned NSRC = iflag_pkg::SRC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC:0]   wdata_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] sel;
  logic            set_mode;

  assign sel      = wdata_i[NSRC-1:0];
  assign set_mode = wdata_i[NSRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (wr_i) begin
      if (set_mode)    mask_q <= mask_q | sel;
      else             mask_q <= mask_q & ~sel;
    end
  end

  assign mask_o = mask_q;

  a_r6_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set_mode) |=> ((mask_q & $past(sel)) == $past(sel)
                            && (mask_q & ~$past(sel)) == ($past(mask_q) & ~$past(sel))));
  a_r7_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !set_mode) |=> ((mask_q & $past(sel)) == '0
                             && (mask_q & ~$past(sel)) == ($past(mask_q) & ~$past(sel))));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NSRC = iflag_pkg::SRC_W
) (
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            any_o,
  output logic            irq_no
);
  assign any_o  = |(flag_i & mask_i);
  assign irq_no = ~any_o;
endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit #(
  parameter int unsigned NSRC      = iflag_pkg::SRC_W,
  parameter bit          HAS_SHIFT = 1'b0,
  localparam int unsigned DW       = NSRC + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            flag_wr_i,
  input  logic            mask_wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   flag_rdata_o,
  output logic [DW-1:0]   mask_rdata_o,
  output logic            irq_no
);
  logic [NSRC-1:0] flags, mask;
  logic            any;

  iflag_bank #(.NSRC(NSRC), .HAS_SHIFT(HAS_SHIFT)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_i),
    .clr_i   (clr_i),
    .wr_i    (flag_wr_i),
    .wdata_i (wdata_i[NSRC-1:0]),
    .flag_o  (flags)
  );

  ien_mask #(.NSRC(NSRC)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr_i),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  irq_summary #(.NSRC(NSRC)) i_sum (
    .flag_i  (flags),
    .mask_i  (mask),
    .any_o   (any),
    .irq_no  (irq_no)
  );

  assign flag_rdata_o = {any, flags};
  assign mask_rdata_o = {1'b1, mask};

  a_r10_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(|(flag_rdata_o[NSRC-1:0] & mask_rdata_o[NSRC-1:0])));
  a_r8_mask_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_rdata_o[NSRC]);
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (flags == '0 && mask == '0));
endmodule

// File: tb/test_intr_flag_unit.sv
module test_intr_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] set_s = '0, clr_s = '0;
  logic       fwr = 1'b0, mwr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] frd, mrd;
  logic       irq_n;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [6:0] fm = '0, mm = '0;
  localparam logic [6:0] LIVE = 7'h7B;  // bit 2 absent (HAS_SHIFT = 0)

  always #2 clk = ~clk;

  intr_flag_unit i_intr_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .clr_i(clr_s),
    .flag_wr_i(fwr), .mask_wr_i(mwr), .wdata_i(wd),
    .flag_rdata_o(frd), .mask_rdata_o(mrd), .irq_no(irq_n)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    logic any;
    any = |(fm & mm);
    chk({req, "/R9 flag read"}, frd, {any, fm});
    chk({req, "/R8 mask read"}, mrd, {1'b1, mm});
    chk({req, "/R10 irq"}, {7'b0, irq_n}, {7'b0, ~any});
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic apply(string req, logic [6:0] s, logic [6:0] c,
                       logic fw, logic mw, logic [7:0] d);
    logic [6:0] creq;
    set_s = s; clr_s = c; fwr = fw; mwr = mw; wd = d;
    @(posedge clk);
    @(negedge clk);
    creq = c | (fw ? d[6:0] : 7'h0);
    fm = (s | (fm & ~creq)) & LIVE;
    if (mw) mm = d[7] ? (mm | d[6:0]) : (mm & ~d[6:0]);
    set_s = '0; clr_s = '0; fwr = 1'b0; mwr = 1'b0; wd = '0;
    chk_all(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    @(negedge clk);
    chk_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset");

    // Per-bit directed cases
    apply("R6 enable all", '0, '0, 1'b0, 1'b1, 8'hFF);
    for (int k = 0; k < 7; k++) begin
      apply(k == 2 ? "R11 shift slot" : "R2 set pulse", 7'(1) << k, '0, 1'b0, 1'b0, '0);
      apply("R4 clear pulse", '0, 7'(1) << k, 1'b0, 1'b0, '0);
      apply("R2 set again", 7'(1) << k, '0, 1'b0, 1'b0, '0);
      apply("R3 write clear", '0, '0, 1'b1, 1'b0, {1'b0, 7'(1) << k});
      apply("R5 set vs pulse", 7'(1) << k, 7'(1) << k, 1'b0, 1'b0, '0);
      apply("R5 set vs write", 7'(1) << k, '0, 1'b1, 1'b0, 8'h7F);
      apply("R3 clear others keep", '0, '0, 1'b1, 1'b0, {1'b0, ~(7'(1) << k)});
      apply("R3 clear last", '0, '0, 1'b1, 1'b0, 8'h7F);
    end
    apply("R7 disable all", '0, '0, 1'b0, 1'b1, 8'h7F);

    // Sweep every flag pattern against a spread of mask patterns
    for (int f = 0; f < 128; f++) begin
      apply("R2 load pattern", 7'(f), '0, 1'b0, 1'b0, '0);
      for (int m = 0; m < 128; m += 13) begin
        apply("R6 mask set", '0, '0, 1'b0, 1'b1, {1'b1, 7'(m)});
        apply("R7 mask clear", '0, '0, 1'b0, 1'b1, {1'b0, 7'(m ^ 7'h55)});
      end
      apply("R3 partial clear", '0, '0, 1'b1, 1'b0, {1'b1, 7'(f * 5)});
      apply("R3 clear all", '0, '0, 1'b1, 1'b0, 8'hFF);
    end

    // Pseudo-random overlap of all inputs
    lf = 32'hACE1_2345;
    for (int i = 0; i < 4000; i++) begin
      lf = lf[0] ? ((lf >> 1) ^ 32'hA300_0001) : (lf >> 1);
      apply("R5 random mix", lf[6:0] & lf[13:7], lf[20:14] & lf[27:21],
            lf[28], lf[29] & lf[30], {lf[31], lf[16:10]});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule